// File: doc/BRIEF.md
# Iterative Keccak-f[1600] Permutation Core

This block runs the full 24-round Keccak-f permutation over a 1600-bit state. The state is held as twenty-five 64-bit lanes in one register, and one complete round is computed in each clock cycle. A sponge controller outside this block loads the state while the core is idle and pulses a start strobe. It then supplies the 64-bit round constant that matches the round index the core exports. Twenty-four cycles later the permuted state is available on the output and a one-cycle done pulse marks completion.

Inside a round, the column-parity correction, lane rotation, lane relocation, nonlinear row mix and constant injection are not separated by registers. Each output lane is one combinational function of the registered lanes and the round constant. The result is written back on the same clock edge.

Top module: `keccak_f1600_core`

## Requirements
- R1: While reset is high and in the cycle after it, `busy` and `done` are 0, `round_idx` is 0 and `state_out` is all zeros.
- R2: A `load_en` while idle copies `load_state` into the state, visible on `state_out` one cycle later. Lane (x,y) occupies bits [64*(x+5y) +: 64], and bit 0 of the lane is its least significant bit.
- R3: A `start` while idle raises `busy` one cycle later with `round_idx` at 0. While busy, `round_idx` increases by one every cycle.
- R4: `busy` stays high for exactly 24 cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again, and `round_idx` then returns to 0.
- R5: Each round computes C[x] as the XOR of lanes (x,0)..(x,4). Every lane of column x is then XORed with C[x-1] ^ rotl(C[x+1],1). Lane (x,y) is rotated left by its offset and moved to (y,(2x+3y) mod 5). Each lane is then set to B[x,y] ^ (~B[x+1,y] & B[x+2,y]). The rotation offset of the lane reached at step t, counting from (1,0), is (t+1)(t+2)/2 mod 64, and lane (0,0) is not rotated. With the standard constants, the all-zero state maps to lane (0,0) = 64'hF1258F7940E1DDE7.
- R6: The constant on `round_const` in a busy cycle is XORed into lane (0,0) of that round's result only, and no other lane depends on it.
- R7: A `start` while busy is ignored: the run length and the result are unchanged.
- R8: A `load_en` while busy is ignored: the result is unchanged.
- R9: While idle with `load_en` low, `state_out` holds its value.
- R10: A `start` in the cycle `done` is high begins a new permutation on the just-finished result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_state` into the state (idle only) |
| load_state | input | 1600 | State to load, lane (x,y) at bits 64*(x+5y) |
| start | input | 1 | Begin a permutation (idle only) |
| round_const | input | 64 | Constant for the round shown on `round_idx` |
| state_out | output | 1600 | Registered state |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | One-cycle pulse after the last round |
| round_idx | output | 5 | Round currently being computed |

## Verification
Results are compared against a bench-side permutation model, which is itself checked against the known image of the all-zero state. A wrong rotation offset or a wrong lane relocation corrupts every lane of that result. Non-standard constant sequences show whether iota reaches lanes other than (0,0), or misses a round. Strobes injected mid-run expose a core that restarts or accepts a load while busy: the run would then last longer than 24 cycles or end in the wrong state. Issuing a start in the done cycle catches a controller that misses a back-to-back request, and a load test checks the lane-to-bit mapping.

// File: rtl/keccak_pkg.sv
package keccak_pkg;

  localparam int GRID = 5;
  localparam int NUM_LANES = GRID * GRID;

  // Rotation amount of lane (x,y), reduced modulo the lane width.
  function automatic int rho_offset(input int x, input int y, input int lane_w);
    int cx;
    int cy;
    int nx;
    cx = 1;
    cy = 0;
    if (x == 0 && y == 0) return 0;
    for (int t = 0; t < NUM_LANES - 1; t++) begin
      if (cx == x && cy == y) return ((t + 1) * (t + 2) / 2) % lane_w;
      nx = cy;
      cy = (2 * cx + 3 * cy) % GRID;
      cx = nx;
    end
    return 0;
  endfunction

  // Lane number inside the flat state vector.
  function automatic int lane_index(input int x, input int y);
    return x + GRID * y;
  endfunction

endpackage

// File: rtl/keccak_theta_d.sv
module keccak_theta_d #(
  parameter int LANE_W = 64,
  localparam int STATE_W = keccak_pkg::NUM_LANES * LANE_W,
  localparam int D_W = keccak_pkg::GRID * LANE_W
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [D_W-1:0]     d_o
);
  import keccak_pkg::*;

  logic [LANE_W-1:0] parity [GRID];

  for (genvar gx = 0; gx < GRID; gx++) begin : g_col
    always_comb begin
      parity[gx] = '0;
      for (int gy = 0; gy < GRID; gy++)
        parity[gx] ^= state_i[LANE_W*lane_index(gx, gy) +: LANE_W];
    end
  end

  for (genvar gx = 0; gx < GRID; gx++) begin : g_d
    localparam int XL = (gx + GRID - 1) % GRID;
    localparam int XR = (gx + 1) % GRID;
    assign d_o[LANE_W*gx +: LANE_W] =
      parity[XL] ^ {parity[XR][LANE_W-2:0], parity[XR][LANE_W-1]};
  end

endmodule

// File: rtl/keccak_lane_mix.sv
module keccak_lane_mix #(
  parameter int LANE_W = 64,
  parameter int SX = 0,
  parameter int SY = 0
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_W-1:0] d_i,
  output logic [LANE_W-1:0] lane_o
);
  import keccak_pkg::*;

  localparam int ROT = rho_offset(SX, SY, LANE_W);

  logic [LANE_W-1:0] corrected;
  assign corrected = lane_i ^ d_i;

  if (ROT == 0) begin : g_norot
    assign lane_o = corrected;
  end else begin : g_rot
    assign lane_o = {corrected[LANE_W-1-ROT:0], corrected[LANE_W-1:LANE_W-ROT]};
  end

endmodule

// File: rtl/keccak_round_ctrl.sv
module keccak_round_ctrl #(
  parameter int NUM_ROUNDS = 24,
  localparam int ROUND_W = $clog2(NUM_ROUNDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [ROUND_W-1:0] round_idx
);
  localparam logic [ROUND_W-1:0] LAST = ROUND_W'(NUM_ROUNDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      round_idx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          round_idx <= '0;
        end
      end else if (round_idx == LAST) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        round_idx <= '0;
      end else begin
        round_idx <= round_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/keccak_f1600_core.sv
module keccak_f1600_core #(
  parameter int LANE_W = 64,
  parameter int NUM_ROUNDS = 24,
  localparam int STATE_W = keccak_pkg::NUM_LANES * LANE_W,
  localparam int ROUND_W = $clog2(NUM_ROUNDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_state,
  input  logic               start,
  input  logic [LANE_W-1:0]  round_const,
  output logic [STATE_W-1:0] state_out,
  output logic               busy,
  output logic               done,
  output logic [ROUND_W-1:0] round_idx
);
  import keccak_pkg::*;

  logic [STATE_W-1:0]     state_q;
  logic [STATE_W-1:0]     next_state;
  logic [GRID*LANE_W-1:0] d_vec;
  logic [STATE_W-1:0]     b_vec;

  keccak_round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .round_idx (round_idx)
  );

  keccak_theta_d #(.LANE_W(LANE_W)) u_theta (
    .state_i (state_q),
    .d_o     (d_vec)
  );

  // Output position (px,py) takes source lane (sx,sy) with px=sy, py=2sx+3sy.
  for (genvar py = 0; py < GRID; py++) begin : g_row
    for (genvar px = 0; px < GRID; px++) begin : g_lane
      localparam int SX = (px + 3 * py) % GRID;
      localparam int SY = px;
      keccak_lane_mix #(.LANE_W(LANE_W), .SX(SX), .SY(SY)) u_mix (
        .lane_i (state_q[LANE_W*lane_index(SX, SY) +: LANE_W]),
        .d_i    (d_vec[LANE_W*SX +: LANE_W]),
        .lane_o (b_vec[LANE_W*lane_index(px, py) +: LANE_W])
      );
    end
  end

  // Row nonlinearity, with the round constant folded into lane (0,0).
  for (genvar py = 0; py < GRID; py++) begin : g_chi_row
    for (genvar px = 0; px < GRID; px++) begin : g_chi
      localparam int I0 = lane_index(px, py);
      localparam int I1 = lane_index((px + 1) % GRID, py);
      localparam int I2 = lane_index((px + 2) % GRID, py);
      logic [LANE_W-1:0] mixed;
      assign mixed = b_vec[LANE_W*I0 +: LANE_W]
                   ^ (~b_vec[LANE_W*I1 +: LANE_W] & b_vec[LANE_W*I2 +: LANE_W]);
      if (I0 == 0) begin : g_iota
        assign next_state[0 +: LANE_W] = mixed ^ round_const;
      end else begin : g_plain
        assign next_state[LANE_W*I0 +: LANE_W] = mixed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= '0;
    else if (busy)    state_q <= next_state;
    else if (load_en) state_q <= load_state;
  end

  assign state_out = state_q;

endmodule

// File: rtl/keccak_f1600_core_chk.sv
module keccak_f1600_core_chk #(
  parameter int STATE_W = 1600,
  parameter int ROUND_W = 5,
  parameter int NUM_ROUNDS = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               load_en,
  input logic [STATE_W-1:0] state_out,
  input logic               busy,
  input logic               done,
  input logic [ROUND_W-1:0] round_idx
);
  localparam logic [ROUND_W-1:0] LAST = ROUND_W'(NUM_ROUNDS - 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && round_idx == '0));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && round_idx == '0));

  // R3
  round_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && round_idx != LAST) |=> (busy && round_idx == $past(round_idx) + 1'b1));

  // R4
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && round_idx == LAST) |=> (!busy && done && round_idx == '0));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load_en) |=> $stable(state_out));

endmodule

bind keccak_f1600_core keccak_f1600_core_chk #(
  .STATE_W(STATE_W), .ROUND_W(ROUND_W), .NUM_ROUNDS(NUM_ROUNDS)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .load_en(load_en),
  .state_out(state_out), .busy(busy), .done(done), .round_idx(round_idx)
);

// File: tb/keccak_f1600_core_bench.sv
module keccak_f1600_core_bench;
  localparam int W  = 64;
  localparam int SW = 1600;
  localparam int NR = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [SW-1:0] load_state = '0;
  logic          start = 1'b0;
  logic [W-1:0]  round_const;
  logic [SW-1:0] state_out;
  logic          busy;
  logic          done;
  logic [4:0]    round_idx;

  logic [W-1:0]  rc_std [NR];
  logic [W-1:0]  rc_alt [NR];
  bit            use_alt = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign round_const = (round_idx < 5'd24) ? (use_alt ? rc_alt[round_idx] : rc_std[round_idx]) : '0;

  keccak_f1600_core u_keccak_f1600_core (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(load_state),
    .start(start), .round_const(round_const), .state_out(state_out),
    .busy(busy), .done(done), .round_idx(round_idx)
  );

  // ---------------- reference model ----------------
  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int r);
    if (r == 0) return v;
    return (v << r) | (v >> (W - r));
  endfunction

  function automatic logic [SW-1:0] model_perm(input logic [SW-1:0] s, input bit alt);
    logic [W-1:0] a [5][5];
    logic [W-1:0] b [5][5];
    logic [W-1:0] c [5];
    int off [5][5];
    int x, y, nx;
    logic [SW-1:0] r;
    off[0][0] = 0;
    x = 1; y = 0;
    for (int t = 0; t < 24; t++) begin
      off[x][y] = ((t + 1) * (t + 2) / 2) % W;
      nx = y; y = (2 * x + 3 * y) % 5; x = nx;
    end
    for (int i = 0; i < 25; i++) a[i % 5][i / 5] = s[W*i +: W];
    for (int rd = 0; rd < NR; rd++) begin
      for (int i = 0; i < 5; i++) c[i] = a[i][0] ^ a[i][1] ^ a[i][2] ^ a[i][3] ^ a[i][4];
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          a[i][j] ^= c[(i + 4) % 5] ^ rotl(c[(i + 1) % 5], 1);
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          b[j][(2 * i + 3 * j) % 5] = rotl(a[i][j], off[i][j]);
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          a[i][j] = b[i][j] ^ (~b[(i + 1) % 5][j] & b[(i + 2) % 5][j]);
      a[0][0] ^= alt ? rc_alt[rd] : rc_std[rd];
    end
    for (int i = 0; i < 25; i++) r[W*i +: W] = a[i % 5][i / 5];
    return r;
  endfunction

  function automatic logic [W-1:0] xs64(input logic [W-1:0] v);
    logic [W-1:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 7);
    return t ^ (t << 17);
  endfunction

  function automatic logic [SW-1:0] make_state(input logic [W-1:0] seed);
    logic [SW-1:0] s;
    logic [W-1:0] v;
    v = seed;
    for (int i = 0; i < 25; i++) begin
      v = xs64(v);
      s[W*i +: W] = v;
    end
    return s;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input logic [SW-1:0] act, input logic [SW-1:0] exp, input string req);
    int bad;
    bad = -1;
    for (int i = 24; i >= 0; i--) if (act[W*i +: W] !== exp[W*i +: W]) bad = i;
    n_checks++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: lane %0d actual %h expected %h", req, bad, act[W*bad +: W], exp[W*bad +: W]);
    end
  endtask

  task automatic load(input logic [SW-1:0] s);
    load_en = 1'b1; load_state = s;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Starts a run on the loaded state; optionally pokes start or load mid-run.
  task automatic run_perm(input logic [SW-1:0] exp, input string req,
                          input bit poke_start, input bit poke_load);
    int cyc;
    bit rounds_ok;
    cyc = 0; rounds_ok = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 40) begin
      if (round_idx != 5'(cyc)) rounds_ok = 1'b0;
      if (poke_start && cyc == 5) start = 1'b1;
      if (poke_load && cyc == 7) begin load_en = 1'b1; load_state = ~exp; end
      @(negedge clk);
      start = 1'b0; load_en = 1'b0;
      cyc++;
    end
    check(rounds_ok, "R3 round index sequence", 64'(rounds_ok), 64'd1);
    check(cyc == NR, "R4 busy cycle count", 64'(cyc), 64'(NR));
    check(done === 1'b1 && busy === 1'b0, "R4 done with busy low", {62'd0, done, busy}, 64'd2);
    check(round_idx == 5'd0, "R4 round index back to 0", 64'(round_idx), 64'd0);
    check_state(state_out, exp, req);
    @(negedge clk);
    check(done === 1'b0, "R4 done single cycle", 64'(done), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
    check(round_idx === 5'd0, "R1 round in reset", 64'(round_idx), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check_state(state_out, '0, "R1 state after reset");
  endtask

  task automatic t_load;
    logic [SW-1:0] s;
    for (int i = 0; i < 25; i++) s[W*i +: W] = {56'hA5C3_0F1E_7700_11, 8'(i)};
    load(s);
    check_state(state_out, s, "R2 load copies state");
    // lane (2,3) is lane number 17
    check(state_out[W*17 +: W] == {56'hA5C3_0F1E_7700_11, 8'd17}, "R2 lane (2,3) position",
          state_out[W*17 +: W], {56'hA5C3_0F1E_7700_11, 8'd17});
  endtask

  task automatic t_zero;
    logic [SW-1:0] e;
    e = model_perm('0, 1'b0);
    check(e[W-1:0] == 64'hF1258F7940E1DDE7, "R5 model known answer", e[W-1:0], 64'hF1258F7940E1DDE7);
    load('0);
    run_perm(e, "R5 zero state image", 1'b0, 1'b0);
    check(state_out[W-1:0] == 64'hF1258F7940E1DDE7, "R5 lane (0,0) of zero image",
          state_out[W-1:0], 64'hF1258F7940E1DDE7);
  endtask

  task automatic t_random(input logic [W-1:0] seed);
    logic [SW-1:0] s;
    s = make_state(seed);
    load(s);
    run_perm(model_perm(s, 1'b0), "R5 patterned state", 1'b0, 1'b0);
  endtask

  task automatic t_alt_rc;
    logic [SW-1:0] s;
    s = make_state(64'h0123_4567_89AB_CDEF);
    use_alt = 1'b1;
    load(s);
    run_perm(model_perm(s, 1'b1), "R6 custom constants", 1'b0, 1'b0);
    use_alt = 1'b0;
  endtask

  task automatic t_start_busy;
    logic [SW-1:0] s;
    s = make_state(64'h5555_AAAA_1234_8765);
    load(s);
    run_perm(model_perm(s, 1'b0), "R7 start while busy", 1'b1, 1'b0);
  endtask

  task automatic t_load_busy;
    logic [SW-1:0] s;
    s = make_state(64'hDEAD_BEEF_0BAD_F00D);
    load(s);
    run_perm(model_perm(s, 1'b0), "R8 load while busy", 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    logic [SW-1:0] snap;
    snap = state_out;
    load_state = ~snap;
    repeat (6) @(negedge clk);
    check_state(state_out, snap, "R9 idle hold");
  endtask

  task automatic t_back2back;
    logic [SW-1:0] s;
    logic [SW-1:0] e1;
    int guard;
    s = make_state(64'h0F0F_1111_2222_3333);
    e1 = model_perm(s, 1'b0);
    load(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 40) begin @(negedge clk); guard++; end
    check_state(state_out, e1, "R10 first pass");
    run_perm(model_perm(e1, 1'b0), "R10 back-to-back pass", 1'b0, 1'b0);
  endtask

  // ---------------- main ----------------
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h01;
    for (int r = 0; r < NR; r++) begin
      rc_std[r] = '0;
      for (int j = 0; j < 7; j++) begin
        if (lfsr[0]) rc_std[r][(1 << j) - 1] = 1'b1;
        lfsr = lfsr[7] ? ((lfsr << 1) ^ 8'h71) : (lfsr << 1);
      end
      rc_alt[r] = {8'(r * 37 + 1), 48'h0, 8'(r ^ 8'h5A)};
    end

    t_reset();
    t_load();
    t_zero();
    t_random(64'h9E37_79B9_7F4A_7C15);
    t_random(64'h0000_0000_0000_0001);
    t_alt_rc();
    t_start_busy();
    t_load_busy();
    t_hold();
    t_back2back();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule